// File: doc/BRIEF.md
# Debug Trigger Priority Sequencer

This block gathers every source that can advance or stop a debug session and picks exactly one of them per clock cycle. The sources are a coprocessor software-breakpoint request, a software immediate-trigger bit, a set of comparator match channels and an external tag hit. The winning source drives a small session sequencer. That sequencer has a disarmed state, three intermediate armed states and a final state. The winner also raises breakpoint requests toward the main CPU and the coprocessor, and a pulse that stops trace capture.

Each match channel carries a 3-bit next-state code from its state control register. A range-mode flag ties comparator channels 0 and 2 together. An enable bit gates the coprocessor breakpoint, a second bit gates breakpoints caused by matches and tags, and a select bit chooses between background-debug entry and a software interrupt. Triggers that lose arbitration in a cycle are discarded. They are never held for a later cycle.

Top module: `dbgseq_top`

## Requirements
- R1: In any cycle at most one source acts. The order from highest to lowest is coprocessor breakpoint, immediate trigger, match channels, external tag. A source that loses is dropped and has no effect in that cycle or any later one.
- R2: A coprocessor breakpoint with `cop_en` high moves the state to 0 and pulses `cpu_bkpt` and `trace_stop` on the next cycle. In that same cycle `bdm_mode` equals the `bdm_sel` that was sampled with the request. With `cop_en` low the request is ignored entirely.
- R3: `imm_trig` moves the state to 4 (final) from any state, including 0. It pulses both `cpu_bkpt` and `cop_brk` on the next cycle, whatever the value of `bkpt_en`.
- R4: A winning match on channel c loads the state from `nxt_codes[3c+2:3c]`.
- R5: Among simultaneous matches, a channel whose code is 4 (final) wins over every channel whose code is not 4. The lowest channel wins among the channels with code 4.
- R6: When no simultaneous match has code 4, the lowest-numbered matching channel wins.
- R7: With `range_mode` high, a match on channel 0 suppresses a simultaneous match on channel 2, and this applies even when channel 2's code is 4.
- R8: An external tag in an armed state (1 to 4) moves the state to 0 and pulses `trace_stop` on the next cycle. It also pulses `cpu_bkpt` when `bkpt_en` is high.
- R9: Synchronous reset gives state 0 with all pulse outputs low. In state 0, `arm` moves the state to 1. In state 0, matches and tags are ignored. In any other state, `arm` is ignored.
- R10: A winning match whose code is 5, 6 or 7 leaves the state unchanged and raises no pulse. It still blocks lower-priority sources in that cycle.
- R11: `cpu_bkpt`, `cop_brk`, `bdm_mode` and `trace_stop` are high only in the cycle after an event that calls for them.
- R12: A winning match with code 4 pulses `cpu_bkpt` on the next cycle when `bkpt_en` is high. Such a match raises no `trace_stop` and no `cop_brk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm | input | 1 | Start a session from disarmed |
| cop_req | input | 1 | Coprocessor software-breakpoint request |
| cop_en | input | 1 | Enable for the coprocessor breakpoint |
| bdm_sel | input | 1 | 1: breakpoint enters background debug; 0: software interrupt |
| imm_trig | input | 1 | Software immediate-trigger bit |
| match | input | NUM_CH (4) | Comparator match pulses, one per channel |
| ext_tag | input | 1 | External tag hit at execution |
| range_mode | input | 1 | Comparators 0 and 2 form a range |
| nxt_codes | input | 3*NUM_CH (12) | Next-state code per channel, channel c at bits 3c+2:3c |
| bkpt_en | input | 1 | Enable for breakpoints from matches and tags |
| state | output | 3 | Current state: 0 disarmed, 1 to 3 armed, 4 final |
| cpu_bkpt | output | 1 | Breakpoint request pulse to the main CPU |
| cop_brk | output | 1 | Forced breakpoint pulse to the coprocessor |
| bdm_mode | output | 1 | Mode select that accompanies `cpu_bkpt` |
| trace_stop | output | 1 | Trace-terminate pulse |

## Verification
Every result is due exactly one clock edge after the stimulus. Both `state` and the four pulse outputs are loaded at the edge that samples the triggers. The bench applies inputs on the falling edge, waits for the next rising edge, and reads the outputs on the falling edge after it. Each check therefore observes the result of one stimulus cycle only. The check on the following cycle confirms that the pulses have dropped and that dropped triggers have left no trace.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_ARM1  = 3'd1,
    ST_ARM2  = 3'd2,
    ST_ARM3  = 3'd3,
    ST_FINAL = 3'd4
  } dstate_t;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_COP   = 3'd1,
    SRC_IMM   = 3'd2,
    SRC_MATCH = 3'd3,
    SRC_TAG   = 3'd4,
    SRC_ARM   = 3'd5
  } src_t;

  // A next-state code is usable only when it names an existing state.
  function automatic logic code_ok(input logic [ST_W-1:0] c);
    return c <= ST_W'(ST_FINAL);
  endfunction

  function automatic logic code_is_final(input logic [ST_W-1:0] c);
    return c == ST_W'(ST_FINAL);
  endfunction

  // Sources that produce a pulse on the outputs.
  function automatic logic src_is_event(input src_t s);
    return (s == SRC_COP) || (s == SRC_IMM) || (s == SRC_MATCH) || (s == SRC_TAG);
  endfunction

endpackage

// File: rtl/dbgseq_arb.sv
module dbgseq_arb
  import dbgseq_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int VEC_W = NUM_CH + 3
) (
  input  dstate_t                   cur,
  input  logic                      arm,
  input  logic                      cop_req,
  input  logic                      cop_en,
  input  logic                      imm_req,
  input  logic [NUM_CH-1:0]         match,
  input  logic                      tag,
  input  logic                      range_mode,
  input  logic [NUM_CH*ST_W-1:0]    nxt_codes,
  output src_t                      src,
  output logic [VEC_W-1:0]          win_vec,
  output logic [CH_W-1:0]           win_ch,
  output dstate_t                   target,
  output logic                      move,
  output logic                      to_final,
  output logic [NUM_CH-1:0]         m_live
);

  logic                 armed;
  logic                 cop_go;
  logic [ST_W-1:0]      code   [NUM_CH];
  logic [NUM_CH-1:0]    m_eff;
  logic [NUM_CH-1:0]    fin_hit;
  logic [NUM_CH-1:0]    pool;
  logic [ST_W-1:0]      sel_code;

  assign armed  = (cur != ST_IDLE);
  assign cop_go = cop_req & cop_en;

  function automatic logic [CH_W-1:0] lowest(input logic [NUM_CH-1:0] v);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (v[i]) r = CH_W'(i);
    end
    return r;
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign code[c] = nxt_codes[c*ST_W +: ST_W];
    if (c == 2) begin : g_range
      // channel 2 is the upper bound of the range with channel 0
      assign m_eff[c] = match[c] & ~(range_mode & match[0]);
    end else begin : g_plain
      assign m_eff[c] = match[c];
    end
    assign m_live[c]  = m_eff[c] & armed;
    assign fin_hit[c] = m_live[c] & code_is_final(code[c]);
  end

  always_comb begin
    pool     = (|fin_hit) ? fin_hit : m_live;
    win_ch   = lowest(pool);
    sel_code = code[win_ch];
    src      = SRC_NONE;
    win_vec  = '0;
    target   = cur;
    move     = 1'b0;
    to_final = 1'b0;
    if (cop_go) begin
      src        = SRC_COP;
      win_vec[0] = 1'b1;
      target     = ST_IDLE;
      move       = 1'b1;
    end else if (imm_req) begin
      src        = SRC_IMM;
      win_vec[1] = 1'b1;
      target     = ST_FINAL;
      move       = 1'b1;
    end else if (|m_live) begin
      src                     = SRC_MATCH;
      win_vec[int'(win_ch)+2] = 1'b1;
      if (code_ok(sel_code)) begin
        target   = dstate_t'(sel_code);
        move     = 1'b1;
        to_final = code_is_final(sel_code);
      end
    end else if (tag && armed) begin
      src              = SRC_TAG;
      win_vec[VEC_W-1] = 1'b1;
      target           = ST_IDLE;
      move             = 1'b1;
    end else if (arm && !armed) begin
      src    = SRC_ARM;
      target = ST_ARM1;
      move   = 1'b1;
    end
  end

endmodule

// File: rtl/dbgseq_fsm.sv
module dbgseq_fsm
  import dbgseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    move,
  input  dstate_t target,
  output dstate_t cur
);

  always_ff @(posedge clk) begin
    if (rst)       cur <= ST_IDLE;
    else if (move) cur <= target;
  end

  p_hold_without_move_r9: assert property (@(posedge clk) disable iff (rst)
    !move |=> $stable(cur))
    else $error("state changed without a winning source");

  p_state_legal_r10: assert property (@(posedge clk) disable iff (rst)
    cur <= ST_FINAL)
    else $error("state left the legal range");

endmodule

// File: rtl/dbgseq_pulse.sv
module dbgseq_pulse
  import dbgseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  src_t src,
  input  logic to_final,
  input  logic bkpt_en,
  input  logic bdm_sel,
  output logic cpu_bkpt,
  output logic cop_brk,
  output logic bdm_mode,
  output logic trace_stop
);

  logic cpu_nxt;
  logic cop_nxt;
  logic trace_nxt;

  always_comb begin
    cpu_nxt   = (src == SRC_COP) || (src == SRC_IMM) ||
                (bkpt_en && ((src == SRC_TAG) || ((src == SRC_MATCH) && to_final)));
    cop_nxt   = (src == SRC_IMM);
    trace_nxt = (src == SRC_COP) || (src == SRC_TAG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_bkpt   <= 1'b0;
      cop_brk    <= 1'b0;
      bdm_mode   <= 1'b0;
      trace_stop <= 1'b0;
    end else begin
      cpu_bkpt   <= cpu_nxt;
      cop_brk    <= cop_nxt;
      bdm_mode   <= cpu_nxt & bdm_sel;
      trace_stop <= trace_nxt;
    end
  end

  p_cop_with_cpu_r3: assert property (@(posedge clk) disable iff (rst)
    cop_brk |-> cpu_bkpt)
    else $error("coprocessor breakpoint without CPU breakpoint");

  p_mode_with_bkpt_r2: assert property (@(posedge clk) disable iff (rst)
    bdm_mode |-> cpu_bkpt)
    else $error("mode select raised without a breakpoint");

endmodule

// File: rtl/dbgseq_top.sv
module dbgseq_top
  import dbgseq_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int VEC_W = NUM_CH + 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   arm,
  input  logic                   cop_req,
  input  logic                   cop_en,
  input  logic                   bdm_sel,
  input  logic                   imm_trig,
  input  logic [NUM_CH-1:0]      match,
  input  logic                   ext_tag,
  input  logic                   range_mode,
  input  logic [NUM_CH*ST_W-1:0] nxt_codes,
  input  logic                   bkpt_en,
  output logic [ST_W-1:0]        state,
  output logic                   cpu_bkpt,
  output logic                   cop_brk,
  output logic                   bdm_mode,
  output logic                   trace_stop
);

  dstate_t             cur;
  dstate_t             target;
  src_t                src;
  logic [VEC_W-1:0]    win_vec;
  logic [CH_W-1:0]     win_ch;
  logic                move;
  logic                to_final;
  logic [NUM_CH-1:0]   m_live;
  logic                cop_go;
  logic                armed;

  assign cop_go = cop_req & cop_en;
  assign armed  = (cur != ST_IDLE);
  assign state  = cur;

  dbgseq_arb #(.NUM_CH(NUM_CH)) u_arb (
    .cur        (cur),
    .arm        (arm),
    .cop_req    (cop_req),
    .cop_en     (cop_en),
    .imm_req    (imm_trig),
    .match      (match),
    .tag        (ext_tag),
    .range_mode (range_mode),
    .nxt_codes  (nxt_codes),
    .src        (src),
    .win_vec    (win_vec),
    .win_ch     (win_ch),
    .target     (target),
    .move       (move),
    .to_final   (to_final),
    .m_live     (m_live)
  );

  dbgseq_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .move   (move),
    .target (target),
    .cur    (cur)
  );

  dbgseq_pulse u_pulse (
    .clk        (clk),
    .rst        (rst),
    .src        (src),
    .to_final   (to_final),
    .bkpt_en    (bkpt_en),
    .bdm_sel    (bdm_sel),
    .cpu_bkpt   (cpu_bkpt),
    .cop_brk    (cop_brk),
    .bdm_mode   (bdm_mode),
    .trace_stop (trace_stop)
  );

  p_one_winner_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_vec))
    else $error("more than one trigger source won");

  p_cop_effect_r2: assert property (@(posedge clk) disable iff (rst)
    cop_go |=> (cur == ST_IDLE) && cpu_bkpt && trace_stop)
    else $error("coprocessor breakpoint did not disarm");

  p_imm_effect_r3: assert property (@(posedge clk) disable iff (rst)
    (imm_trig && !cop_go) |=> (cur == ST_FINAL) && cpu_bkpt && cop_brk)
    else $error("immediate trigger did not reach final");

  p_range_suppress_r7: assert property (@(posedge clk) disable iff (rst)
    (range_mode && match[0] && armed) |-> !win_vec[4])
    else $error("channel 2 won against channel 0 in range mode");

  p_trace_disarms_r8: assert property (@(posedge clk) disable iff (rst)
    trace_stop |-> (cur == ST_IDLE))
    else $error("trace stop without disarm");

  p_idle_ignores_r9: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (m_live == '0))
    else $error("match acted while disarmed");

  p_pulse_clear_r11: assert property (@(posedge clk) disable iff (rst)
    !src_is_event(src) |=> !cpu_bkpt && !cop_brk && !trace_stop)
    else $error("pulse without an event");

endmodule

// File: tb/dbgseq_top_tb.sv
`timescale 1ns/1ps
module dbgseq_top_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        arm, cop_req, cop_en, bdm_sel, imm_trig, ext_tag, range_mode, bkpt_en;
  logic [3:0]  match;
  logic [11:0] nxt_codes;
  logic [2:0]  state;
  logic        cpu_bkpt, cop_brk, bdm_mode, trace_stop;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbgseq_top u_dut (
    .clk(clk), .rst(rst), .arm(arm), .cop_req(cop_req), .cop_en(cop_en),
    .bdm_sel(bdm_sel), .imm_trig(imm_trig), .match(match), .ext_tag(ext_tag),
    .range_mode(range_mode), .nxt_codes(nxt_codes), .bkpt_en(bkpt_en),
    .state(state), .cpu_bkpt(cpu_bkpt), .cop_brk(cop_brk),
    .bdm_mode(bdm_mode), .trace_stop(trace_stop)
  );

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(string req, int st, int cpu, int cop, int bdm, int tr);
    chk(req, "state", int'(state), st);
    chk(req, "cpu_bkpt", int'(cpu_bkpt), cpu);
    chk(req, "cop_brk", int'(cop_brk), cop);
    chk(req, "bdm_mode", int'(bdm_mode), bdm);
    chk(req, "trace_stop", int'(trace_stop), tr);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    arm = 0; cop_req = 0; imm_trig = 0; match = 4'b0; ext_tag = 0;
  endtask

  task automatic set_code(int ch, int code);
    nxt_codes[ch*3 +: 3] = 3'(code);
  endtask

  task automatic do_reset();
    clear_in();
    cop_en = 1; bdm_sel = 0; range_mode = 0; bkpt_en = 1; nxt_codes = '0;
    rst = 1; tick(); tick(); rst = 0;
  endtask

  // reach an armed state via arm and a channel-0 match
  task automatic reach(int s);
    do_reset();
    arm = 1; tick(); clear_in();
    if (s != 1) begin
      set_code(0, s); match = 4'b0001; tick(); clear_in();
    end
    tick();
  endtask

  task automatic t_reset_arm();
    do_reset();
    chk_out("R9", 0, 0, 0, 0, 0);
    set_code(0, 3); match = 4'b0001; ext_tag = 1; tick(); clear_in();
    chk_out("R9", 0, 0, 0, 0, 0);
    arm = 1; tick(); clear_in();
    chk_out("R9", 1, 0, 0, 0, 0);
    arm = 1; tick(); clear_in();
    chk("R9", "arm ignored when armed", int'(state), 1);
  endtask

  task automatic t_match_moves();
    reach(1);
    set_code(1, 2); match = 4'b0010; tick(); clear_in();
    chk_out("R4", 2, 0, 0, 0, 0);
    set_code(3, 3); match = 4'b1000; tick(); clear_in();
    chk_out("R4", 3, 0, 0, 0, 0);
  endtask

  task automatic t_lowest_and_drop();
    reach(1);
    set_code(1, 2); set_code(3, 3); match = 4'b1010; ext_tag = 1; tick(); clear_in();
    chk_out("R6", 2, 0, 0, 0, 0);
    tick();
    chk_out("R1", 2, 0, 0, 0, 0);
  endtask

  task automatic t_final_override();
    reach(1);
    set_code(0, 2); set_code(2, 4); match = 4'b0101; tick(); clear_in();
    chk_out("R5", 4, 1, 0, 0, 0);
    tick();
    chk_out("R11", 4, 0, 0, 0, 0);
    reach(1);
    bkpt_en = 0;
    set_code(1, 4); match = 4'b0010; tick(); clear_in();
    chk_out("R12", 4, 0, 0, 0, 0);
  endtask

  task automatic t_range();
    reach(1);
    range_mode = 1;
    set_code(0, 2); set_code(2, 3); match = 4'b0101; tick(); clear_in();
    chk_out("R7", 2, 0, 0, 0, 0);
    reach(1);
    range_mode = 1;
    set_code(0, 2); set_code(2, 4); match = 4'b0101; tick(); clear_in();
    chk_out("R7", 2, 0, 0, 0, 0);
    reach(1);
    range_mode = 1;
    set_code(2, 3); match = 4'b0100; tick(); clear_in();
    chk("R7", "channel 2 alone", int'(state), 3);
  endtask

  task automatic t_cop();
    reach(2);
    bdm_sel = 1; cop_req = 1; imm_trig = 1; set_code(0, 3); match = 4'b0001;
    tick(); clear_in();
    chk_out("R2", 0, 1, 0, 1, 1);
    tick();
    chk_out("R11", 0, 0, 0, 0, 0);
    reach(3);
    bdm_sel = 0; cop_req = 1; tick(); clear_in();
    chk_out("R2", 0, 1, 0, 0, 1);
    reach(2);
    cop_en = 0; cop_req = 1; imm_trig = 1; tick(); clear_in();
    chk_out("R2", 4, 1, 1, 0, 0);
    reach(2);
    cop_en = 0; cop_req = 1; tick(); clear_in();
    chk_out("R2", 2, 0, 0, 0, 0);
  endtask

  task automatic t_imm();
    do_reset();
    bkpt_en = 0; imm_trig = 1; tick(); clear_in();
    chk_out("R3", 4, 1, 1, 0, 0);
    tick();
    chk_out("R11", 4, 0, 0, 0, 0);
    reach(1);
    imm_trig = 1; set_code(0, 2); match = 4'b0001; tick(); clear_in();
    chk_out("R1", 4, 1, 1, 0, 0);
  endtask

  task automatic t_tag();
    reach(3);
    bdm_sel = 1; ext_tag = 1; tick(); clear_in();
    chk_out("R8", 0, 1, 0, 1, 1);
    reach(4);
    bkpt_en = 0; ext_tag = 1; tick(); clear_in();
    chk_out("R8", 0, 0, 0, 0, 1);
  endtask

  task automatic t_invalid();
    reach(2);
    set_code(0, 6); set_code(1, 3); match = 4'b0011; ext_tag = 1; tick(); clear_in();
    chk_out("R10", 2, 0, 0, 0, 0);
    set_code(2, 7); match = 4'b0100; tick(); clear_in();
    chk_out("R10", 2, 0, 0, 0, 0);
  endtask

  initial begin
    rst = 1;
    clear_in();
    cop_en = 1; bdm_sel = 0; range_mode = 0; bkpt_en = 1; nxt_codes = '0;
    @(negedge clk);
    t_reset_arm();
    t_match_moves();
    t_lowest_and_drop();
    t_final_override();
    t_range();
    t_cop();
    t_imm();
    t_tag();
    t_invalid();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule